// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire serial link: an active-high chip select, a serial clock and a single data line that is driven in both directions. It turns serial transfers into single-cycle read and write strokes on a parallel register port. All three serial pins are brought into the system clock domain through synchronisers, so the serial clock must run several times slower than the system clock.

Each transfer opens with a command byte. Bit 7 of this byte selects write when it is 1 and read when it is 0. Bits 6:0 give the starting register address. One or more data bytes follow, and the address steps after every byte. The step after the last implemented register goes back to address zero. Addresses above the last implemented register are reserved: they never produce a write stroke, and they read as zero. While a byte is being read out of the converter result register, the block holds a lock output high so that the register is not updated during the read. Dropping chip select releases the lock and abandons the transfer.

Top module: `serial_reg_port`

## Requirements
- R1: A low chip select puts the data line in high impedance (`sdio_oe` low) in the same cycle. It also ends any transfer, so the next high chip select starts again with a command byte.
- R2: The first byte after chip select rises is the command. It is received LSB first. Bit 7 set means write, bit 7 clear means read, and bits 6:0 are the start address.
- R3: In a write transfer, each data byte is sampled on rising serial clock edges, LSB first. Once all 8 bits are in, one single-cycle `reg_wr_o` stroke carries the address and the byte.
- R4: In a read transfer, data bits are driven LSB first on falling serial clock edges. The first bit is driven on the falling edge after the last command bit, and `sdio_oe` stays low until that edge.
- R5: The address moves up by one after every data byte. The step after address 0x0E goes to 0x00, and the step after 0x7F also goes to 0x00.
- R6: Addresses 0x0F to 0x7F produce no write stroke, and they read as 0x00 whatever `reg_rdata_i` carries.
- R7: If chip select falls before the eighth bit of a write data byte, that byte is discarded and causes no write.
- R8: `adc_hold_o` is high during the read-out of address 0x0E. It drops when that byte completes or when chip select falls.
- R9: After reset the port is idle: `sdio_oe`, `reg_wr_o`, `reg_rd_o` and `adc_hold_o` are low, and `reg_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Data line, input sense |
| sdio_o | output | 1 | Data line, driven value |
| sdio_oe | output | 1 | Data line output enable |
| reg_addr_o | output | 7 | Register address |
| reg_wr_o | output | 1 | Single-cycle write stroke |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | Single-cycle read stroke, when a read byte is loaded |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |
| adc_hold_o | output | 1 | Update lock for the converter result register |

## Verification
The port is tried with single-byte writes and reads, bursts that cross the 0x0E-to-0x00 wrap, bursts that start in the reserved range and roll over 0x7F, a write truncated after four data bits, and a read of 0x0E cut short by chip select. The single transfers separate bit ordering and command decoding from addressing. The bursts separate the wrap rule from plain 7-bit counting. The reserved cases show that zero-forcing happens in the port, because the register model returns a non-zero pattern there. The aborted read shows that the line is released and the lock drops, and that the next transfer still decodes its command correctly.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/srp_edge.sv
module srp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              din_i,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              at_zero_o
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    byte_d = byte_q;
    done_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (rise_i) begin
      sh_d = {din_i, sh_q[DATA_W-1:1]};
      if (cnt_q == LAST_BIT) begin
        cnt_d  = '0;
        done_d = 1'b1;
        byte_d = {din_i, sh_q[DATA_W-1:1]};
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      byte_q <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      byte_q <= byte_d;
      done_q <= done_d;
    end
  end

  assign done_o    = done_q;
  assign byte_o    = byte_q;
  assign at_zero_o = (cnt_q == '0);

  // R3: a completed byte is announced for exactly one cycle
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LAST_ADDR   = 14,
  parameter int HOLD_ADDR   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              adc_hold_o
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);
  localparam logic [ADDR_W-1:0] HOLD_A = ADDR_W'(HOLD_ADDR);

  logic cs_s, sclk_s, sdi_s;
  logic sclk_rise, sclk_fall;
  logic byte_done, bit_zero;
  logic [DATA_W-1:0] rx_byte;

  srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_i, sclk_i, sdio_i}),
    .q_o   ({cs_s, sclk_s, sdi_s})
  );

  srp_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (sclk_s),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  srp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (~cs_s),
    .rise_i    (sclk_rise),
    .din_i     (sdi_s),
    .done_o    (byte_done),
    .byte_o    (rx_byte),
    .at_zero_o (bit_zero)
  );

  phase_e            phase_q, phase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              adv_q, adv_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              rd_q, rd_d;
  logic              oe_q, oe_d;
  logic              sdo_q, sdo_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              rsv;
  logic [DATA_W-1:0] rdata_eff;

  assign rsv       = (addr_q > LAST_A);
  assign rdata_eff = rsv ? '0 : reg_rdata_i;

  always_comb begin
    phase_d = phase_q;
    addr_d  = addr_q;
    adv_d   = 1'b0;
    wr_d    = 1'b0;
    wdata_d = wdata_q;
    rd_d    = 1'b0;
    oe_d    = oe_q;
    sdo_d   = sdo_q;
    tx_d    = tx_q;
    if (!cs_s) begin
      phase_d = PH_CMD;
      oe_d    = 1'b0;
    end else begin
      if (adv_q) begin
        addr_d = (addr_q == LAST_A) ? '0 : addr_q + ADDR_W'(1);
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            phase_d = rx_byte[DATA_W-1] ? PH_WR : PH_RD;
            addr_d  = rx_byte[ADDR_W-1:0];
          end
          PH_WR: begin
            wr_d    = ~rsv;
            wdata_d = rx_byte;
            adv_d   = 1'b1;
          end
          default: adv_d = 1'b1;
        endcase
      end
      if (sclk_fall && phase_q == PH_RD) begin
        oe_d = 1'b1;
        if (bit_zero) begin
          rd_d  = 1'b1;
          sdo_d = rdata_eff[0];
          tx_d  = rdata_eff >> 1;
        end else begin
          sdo_d = tx_q[0];
          tx_d  = tx_q >> 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      adv_q   <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      sdo_q   <= 1'b0;
      tx_q    <= '0;
    end else begin
      phase_q <= phase_d;
      addr_q  <= addr_d;
      adv_q   <= adv_d;
      wr_q    <= wr_d;
      wdata_q <= wdata_d;
      rd_q    <= rd_d;
      oe_q    <= oe_d;
      sdo_q   <= sdo_d;
      tx_q    <= tx_d;
    end
  end

  assign sdio_o      = sdo_q;
  assign sdio_oe     = oe_q & cs_i;
  assign reg_addr_o  = addr_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = rd_q;
  assign adc_hold_o  = cs_s && (phase_q == PH_RD) && (addr_q == HOLD_A);

  // R6: no write stroke ever reaches a reserved address
  assert_no_rsv_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (reg_addr_o <= LAST_A));

  // R5: a write to the last implemented register is followed by address zero
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && reg_addr_o == LAST_A) |=> (reg_addr_o == '0));

  // R8: loading the converter result for read-out happens under the lock
  assert_hold_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_o && reg_addr_o == HOLD_A) |-> adc_hold_o);

  // R4: the data line is only driven in the read data phase
  assert_oe_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (phase_q == PH_RD));

  // R3: write strokes are single-cycle
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);
endmodule

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdio_o, sdio_oe, reg_wr, reg_rd, adc_hold;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_reg_port uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_i        (cs),
    .sclk_i      (sclk),
    .sdio_i      (sdi),
    .sdio_o      (sdio_o),
    .sdio_oe     (sdio_oe),
    .reg_addr_o  (reg_addr),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata),
    .reg_rd_o    (reg_rd),
    .reg_rdata_i (reg_rdata),
    .adc_hold_o  (adc_hold)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] dev_rf [15];
  logic [7:0] exp_rf [15];
  typedef struct packed { logic [6:0] a; logic [7:0] d; } wr_t;
  wr_t wq[$];
  wr_t mon_e;

  always_comb reg_rdata = (reg_addr < 7'd15) ? dev_rf[reg_addr[3:0]] : 8'hA5;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 15; i++) dev_rf[i] <= 8'h00;
    end else if (reg_wr && reg_addr < 7'd15) begin
      dev_rf[reg_addr[3:0]] <= reg_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (!cs) check(!sdio_oe, "R1", "line driven with cs low", sdio_oe, 0);
      if (reg_wr) begin
        if (wq.size() == 0) begin
          check(1'b0, "R6", "unexpected write stroke at address", reg_addr, 0);
        end else begin
          mon_e = wq.pop_front();
          check(reg_addr == mon_e.a && reg_wdata == mon_e.d, "R3",
                "write address/data", {reg_addr, reg_wdata}, {mon_e.a, mon_e.d});
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer();
    cs = 1'b1;
    wait_clk(H);
  endtask

  task automatic end_xfer();
    cs = 1'b0;
    wait_clk(H);
    sclk = 1'b0;
    wait_clk(H);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      sdi  = b[i];
      wait_clk(H);
      sclk = 1'b1;
      wait_clk(H);
    end
  endtask

  function automatic logic [6:0] nxt(input logic [6:0] a);
    return (a == 7'h0E) ? 7'h00 : a + 7'h01;
  endfunction

  function automatic logic [7:0] exp_val(input logic [6:0] a);
    return (a < 7'd15) ? exp_rf[a[3:0]] : 8'h00;
  endfunction

  task automatic expect_wr(input logic [6:0] a, input logic [7:0] d);
    if (a < 7'd15) begin
      wq.push_back('{a: a, d: d});
      exp_rf[a[3:0]] = d;
    end
  endtask

  task automatic write_seq(input logic [6:0] a, input logic [7:0] dq[$]);
    logic [6:0] p;
    p = a;
    begin_xfer();
    put_bits({1'b1, a}, 8);
    foreach (dq[i]) begin
      expect_wr(p, dq[i]);
      put_bits(dq[i], 8);
      p = nxt(p);
    end
    end_xfer();
  endtask

  task automatic get_byte(input logic [6:0] a);
    logic [7:0] got;
    logic h;
    logic oe_seen;
    got = 8'h00;
    h = 1'b0;
    oe_seen = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      wait_clk(H);
      got[i] = sdio_o;
      oe_seen = oe_seen & sdio_oe;
      if (i == 3) h = adc_hold;
      sclk = 1'b1;
      wait_clk(H);
    end
    check(oe_seen, "R4", "line enabled during read byte", oe_seen, 1);
    if (a < 7'd15)
      check(got == exp_val(a), "R4", "read data", got, exp_val(a));
    else
      check(got == 8'h00, "R6", "reserved read data", got, 0);
    check(h == (a == 7'h0E), "R8", "converter hold during read byte", h, (a == 7'h0E));
  endtask

  task automatic read_seq(input logic [6:0] a, input int n);
    logic [6:0] p;
    p = a;
    begin_xfer();
    put_bits({1'b0, a}, 8);
    check(!sdio_oe, "R4", "line idle before first falling edge", sdio_oe, 0);
    for (int k = 0; k < n; k++) begin
      get_byte(p);
      p = nxt(p);
    end
    end_xfer();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) exp_rf[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R9: idle after reset
    check(!sdio_oe && !reg_wr && !reg_rd && !adc_hold && reg_addr == 7'h00,
          "R9", "reset state", {sdio_oe, reg_wr, reg_rd, adc_hold, reg_addr}, 0);

    // R2 R3 R4: single write and read back
    write_seq(7'h03, '{8'h5A});
    read_seq(7'h03, 1);

    // R5: burst write crossing 0x0E to 0x00, then burst read across it
    write_seq(7'h0C, '{8'h11, 8'h22, 8'h33, 8'h44});
    read_seq(7'h0D, 3);

    // R6: reserved writes ignored, reserved reads zero, 0x7F rolls to 0x00
    write_seq(7'h1F, '{8'hFF, 8'h77});
    read_seq(7'h1F, 1);
    write_seq(7'h7E, '{8'h12, 8'h34, 8'h99});
    read_seq(7'h7F, 2);

    // R7: truncated write byte discarded
    begin_xfer();
    put_bits(8'h85, 8);
    put_bits(8'hEE, 4);
    end_xfer();
    read_seq(7'h05, 1);

    // R1 R8: read of 0x0E aborted by chip select
    begin_xfer();
    put_bits(8'h0E, 8);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0;
      wait_clk(H);
      sclk = 1'b1;
      wait_clk(H);
    end
    check(adc_hold, "R8", "hold during 0x0E read", adc_hold, 1);
    cs = 1'b0;
    #1;
    check(!sdio_oe, "R1", "line released at chip select fall", sdio_oe, 0);
    wait_clk(5);
    check(!adc_hold, "R8", "hold released after abort", adc_hold, 0);
    sclk = 1'b0;
    wait_clk(H);

    // R1: next transfer decodes a fresh command
    write_seq(7'h01, '{8'hC3});
    read_seq(7'h01, 1);

    // R5 R8: burst read starting at 0x0E
    read_seq(7'h0E, 3);

    check(wq.size() == 0, "R3", "pending expected writes", wq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule